// File: doc/BRIEF.md
# Access-Extending Wait Generator

This block lengthens accesses to a slow removable card that sits in a processor memory space whose own wait-state logic cannot make a cycle long enough. It runs on the memory clock. When the processor opens a data access to the card (select plus either the read or the write strobe), a small saturating counter begins to run. A registered wait request goes to the processor for a fixed number of clocks, after which the request is dropped. The card's own wait request is merged into the same line, so a card that needs more time can still stretch the cycle.

A configuration input switches the internal extension off. The processor wait then follows only the card's request, which suits fast cards. The wait line has a separate drive enable that is high only while a card data access is in progress, so an external pad can leave the shared wait net floating at all other times. The counter clears as soon as the access ends, so every new access gets the full extension again.

Top module: `wsx_wait_gen`

## Requirements
- R1: After a synchronous reset, and in every cycle that follows a reset edge, `proc_wait` is 0. A reset in the middle of an access restarts the extension from the beginning.
- R2: `proc_wait_oe` is 1 exactly while `acc_sel` is 1 and at least one of `acc_rd` or `acc_wr` is 1. It is 0 otherwise, within the same cycle.
- R3: With `gen_off`=0 and `card_wait`=0, `proc_wait` is 1 in the 2**CNT_W clocks (4 by default) that follow the first clock edge at which the access is seen. It is 0 in the clock after those.
- R4: The counter saturates and does not wrap. However long the access lasts after the release, `proc_wait` stays 0 while `card_wait` is 0.
- R5: During an access, `proc_wait` is the OR of the internal extension and `card_wait`, registered on one clock edge. A card request after the release raises the line again for as many clocks as the request lasts.
- R6: With `gen_off`=1, `proc_wait` during an access equals `card_wait` delayed by one clock, and the internal extension adds no cycles.
- R7: A clock edge with no access clears the extension. An access that begins after a single idle edge gets the full 2**CNT_W-clock extension, whatever the length of the access before it.
- R8: A write strobe (`acc_wr`) alone starts the same extension as a read strobe (`acc_rd`) alone.
- R9: A strobe while `acc_sel` is 0 is not an access: `proc_wait` stays 0 and `proc_wait_oe` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_sel | input | 1 | Card data region selected (chip select with region decode) |
| acc_rd | input | 1 | Processor read (output enable) strobe, active high |
| acc_wr | input | 1 | Processor write strobe, active high |
| card_wait | input | 1 | Wait request from the card, active high |
| gen_off | input | 1 | 1 turns off the internal extension |
| proc_wait | output | 1 | Registered wait request to the processor, active high |
| proc_wait_oe | output | 1 | Drive enable for the shared wait net |

## Verification
The hardest behaviour to bring about is the difference between a saturating counter and a wrapping one. Both produce the same first four wait cycles, so they only differ in an access that lasts well past the release. The stimulus therefore holds accesses for up to twelve clocks and counts wait cycles after the release on their own. It also raises the card request in that late window, to show that the line comes back for exactly the length of the request. A second hard case is a one-edge idle gap, or a reset in the middle of an access: each must restart the count. The bench places accesses back to back with a single idle clock, and applies a reset while the strobe stays asserted.

// File: rtl/wsx_pkg.sv
package wsx_pkg;

    // Default width of the extension counter; the extension lasts 2**width clocks.
    localparam int unsigned WSX_CNT_W_DFLT = 2;

    // Processor-side request seen by the generator in one clock.
    typedef struct packed {
        logic sel;
        logic rd;
        logic wr;
    } wsx_req_t;

    // Phase of the extension, reported by the counter stage.
    typedef enum logic [1:0] {
        WSX_IDLE = 2'd0,
        WSX_RUN  = 2'd1,
        WSX_DONE = 2'd2
    } wsx_phase_e;

    // A card data access exists when selected and either strobe is active.
    function automatic logic wsx_is_access(input wsx_req_t r);
        return r.sel & (r.rd | r.wr);
    endfunction

endpackage

// File: rtl/wsx_count.sv
module wsx_count
    import wsx_pkg::*;
#(
    parameter int unsigned CNT_W = WSX_CNT_W_DFLT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             live,
    output logic [CNT_W-1:0] cnt_q,
    output wsx_phase_e       phase
);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    logic sat_seen_q;

    // The count saturates at CNT_TOP; one more edge marks the extension done.
    always_ff @(posedge clk) begin
        if (rst || !live) begin
            cnt_q      <= '0;
            sat_seen_q <= 1'b0;
        end else begin
            if (cnt_q != CNT_TOP) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (cnt_q == CNT_TOP) begin
                sat_seen_q <= 1'b1;
            end
        end
    end

    always_comb begin
        if (!live) begin
            phase = WSX_IDLE;
        end else if (sat_seen_q) begin
            phase = WSX_DONE;
        end else begin
            phase = WSX_RUN;
        end
    end

endmodule

// File: rtl/wsx_merge.sv
module wsx_merge
    import wsx_pkg::*;
#(
    parameter bit CARD_REG = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       live,
    input  wsx_phase_e phase,
    input  logic       gen_off,
    input  logic       card_wait,
    output logic       wait_q
);
    logic ext_req;
    logic card_req;

    assign ext_req = (phase == WSX_RUN) & ~gen_off;

    generate
        if (CARD_REG) begin : g_card_direct
            assign card_req = card_wait;
        end else begin : g_card_masked
            assign card_req = card_wait & live;
        end
    endgenerate

    // Registered on the memory clock: the processor samples wait synchronously.
    always_ff @(posedge clk) begin
        if (rst) begin
            wait_q <= 1'b0;
        end else begin
            wait_q <= live & (ext_req | card_req);
        end
    end

endmodule

// File: rtl/wsx_wait_gen.sv
module wsx_wait_gen
    import wsx_pkg::*;
#(
    parameter int unsigned CNT_W = WSX_CNT_W_DFLT
) (
    input  logic clk,
    input  logic rst,
    input  logic acc_sel,
    input  logic acc_rd,
    input  logic acc_wr,
    input  logic card_wait,
    input  logic gen_off,
    output logic proc_wait,
    output logic proc_wait_oe
);
    wsx_req_t         req;
    logic             acc_live;
    logic [CNT_W-1:0] ext_cnt;
    wsx_phase_e       ext_phase;
    logic             wait_reg;

    assign req      = '{sel: acc_sel, rd: acc_rd, wr: acc_wr};
    assign acc_live = wsx_is_access(req);

    wsx_count #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst   (rst),
        .live  (acc_live),
        .cnt_q (ext_cnt),
        .phase (ext_phase)
    );

    wsx_merge #(.CARD_REG(1'b1)) u_merge (
        .clk       (clk),
        .rst       (rst),
        .live      (acc_live),
        .phase     (ext_phase),
        .gen_off   (gen_off),
        .card_wait (card_wait),
        .wait_q    (wait_reg)
    );

    assign proc_wait    = wait_reg;
    assign proc_wait_oe = acc_live;

endmodule

// File: rtl/wsx_wait_gen_chk.sv
module wsx_wait_gen_chk #(
    parameter int unsigned CNT_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             acc_sel,
    input logic             card_wait,
    input logic             gen_off,
    input logic             live,
    input logic [CNT_W-1:0] cnt,
    input logic             proc_wait,
    input logic             proc_wait_oe
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    // R1: an idle edge leaves the wait line low.
    p_idle_low_r1: assert property (@(posedge clk) disable iff (rst)
        !live |=> !proc_wait);

    // R9: no drive without the select.
    p_no_sel_r9: assert property (@(posedge clk) disable iff (rst)
        !acc_sel |-> !proc_wait_oe);

    // R3: the first edge of an enabled access raises wait.
    p_start_r3: assert property (@(posedge clk) disable iff (rst)
        (live && !gen_off && cnt == '0) |=> proc_wait);

    // R4: saturated count holds while the access lasts.
    p_sat_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (live && cnt == TOP) |=> (!live || cnt == TOP));

    // R7: an idle edge clears the count.
    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        !live |=> cnt == '0);

    // R5: card request during access always reaches the processor.
    p_card_r5: assert property (@(posedge clk) disable iff (rst)
        (live && card_wait) |=> proc_wait);

    // R6: disabled generator adds nothing.
    p_off_r6: assert property (@(posedge clk) disable iff (rst)
        (live && gen_off && !card_wait) |=> !proc_wait);

endmodule

bind wsx_wait_gen wsx_wait_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .acc_sel      (acc_sel),
    .card_wait    (card_wait),
    .gen_off      (gen_off),
    .live         (acc_live),
    .cnt          (ext_cnt),
    .proc_wait    (proc_wait),
    .proc_wait_oe (proc_wait_oe)
);

// File: tb/test_wsx_wait_gen.sv
`timescale 1ns/1ps
module test_wsx_wait_gen;
    localparam int EXT = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic acc_sel = 1'b0, acc_rd = 1'b0, acc_wr = 1'b0;
    logic card_wait = 1'b0, gen_off = 1'b0;
    logic proc_wait, proc_wait_oe;

    int    n_chk = 0;
    int    n_err = 0;
    string tag = "R1";
    bit    mon_on = 1'b0;
    bit    finished = 1'b0;

    int    acc_n = 0;
    logic  exp_wait = 1'b0;

    always #5 clk = ~clk;

    wsx_wait_gen i_wsx_wait_gen (
        .clk(clk), .rst(rst), .acc_sel(acc_sel), .acc_rd(acc_rd), .acc_wr(acc_wr),
        .card_wait(card_wait), .gen_off(gen_off),
        .proc_wait(proc_wait), .proc_wait_oe(proc_wait_oe)
    );

    // Behavioural reference: counts access edges, no structural copy.
    always @(posedge clk) begin
        logic act;
        act = acc_sel && (acc_rd || acc_wr);
        if (rst || !act) begin
            acc_n    = 0;
            exp_wait <= 1'b0;
        end else begin
            exp_wait <= ((!gen_off && acc_n < EXT) || card_wait);
            acc_n    = acc_n + 1;
        end
    end

    task automatic chk(input string t, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d at %0t", t, got, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (mon_on) begin
            chk({tag, " R2 drive"}, proc_wait_oe, acc_sel && (acc_rd || acc_wr));
            chk({tag, " wait"}, proc_wait, exp_wait);
        end
    end

    task automatic drive(input logic s, input logic r, input logic w,
                         input logic off, input logic cw);
        acc_sel = s; acc_rd = r; acc_wr = w; gen_off = off; card_wait = cw;
    endtask

    // Runs one access of len clocks; card wait high for cycles [cf, ct).
    task automatic run_acc(input logic s, input logic r, input logic w, input logic off,
                           input int len, input int cf, input int ct,
                           output int highs, output int late);
        highs = 0;
        late  = 0;
        for (int i = 0; i <= len; i++) begin
            @(posedge clk); #2;
            if (i < len) drive(s, r, w, off, (i >= cf && i < ct));
            else         drive(1'b0, 1'b0, 1'b0, off, 1'b0);
            @(negedge clk);
            if (proc_wait) begin
                highs++;
                if (i > EXT) late++;
            end
        end
    endtask

    initial begin
        int h, l;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        tag = "R1";
        chk("R1 reset wait", proc_wait, 0);
        chk("R1 reset drive", proc_wait_oe, 0);
        mon_on = 1'b1;

        tag = "R3";
        run_acc(1, 1, 0, 0, 10, 0, 0, h, l);
        chk("R3 read extension length", h, EXT);

        tag = "R4";
        run_acc(1, 1, 0, 0, 12, 0, 0, h, l);
        chk("R4 no wait after release", l, 0);
        chk("R4 total highs long access", h, EXT);

        tag = "R8";
        run_acc(1, 0, 1, 0, 8, 0, 0, h, l);
        chk("R8 write extension length", h, EXT);

        tag = "R5";
        run_acc(1, 1, 0, 0, 10, 0, 8, h, l);
        chk("R5 card held from start", h, 8);
        run_acc(1, 1, 0, 0, 10, 6, 8, h, l);
        chk("R5 late card request", h, EXT + 2);
        chk("R5 late highs after release", l, 2);

        tag = "R6";
        run_acc(1, 1, 0, 1, 8, 0, 0, h, l);
        chk("R6 disabled no card", h, 0);
        run_acc(1, 0, 1, 1, 8, 2, 5, h, l);
        chk("R6 disabled follows card", h, 3);

        tag = "R7";
        run_acc(1, 1, 0, 0, 2, 0, 0, h, l);
        chk("R7 short access", h, 2);
        run_acc(1, 1, 0, 0, 6, 0, 0, h, l);
        chk("R7 restart after one idle edge", h, EXT);
        run_acc(1, 0, 1, 0, 6, 0, 0, h, l);
        chk("R7 back to back", h, EXT);

        tag = "R9";
        run_acc(0, 1, 1, 0, 6, 0, 6, h, l);
        chk("R9 unselected strobe", h, 0);

        tag = "R1";
        @(posedge clk); #2 drive(1, 1, 0, 0, 0);
        repeat (2) @(posedge clk);
        #2 rst = 1'b1;
        @(posedge clk); #2 rst = 1'b0;
        @(negedge clk);
        chk("R1 wait low after reset edge", proc_wait, 0);
        h = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (proc_wait) h++;
        end
        chk("R1 restart after reset", h, EXT);
        @(posedge clk); #2 drive(0, 0, 0, 0, 0);
        repeat (2) @(posedge clk);

        mon_on = 1'b0;
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule